// File: doc/BRIEF.md
# Receive Wander Slip Buffer

This block is a receive elastic store for a 2.048 Mbit/s framed line. Each frame is 32 channels of 8 bits. Line-side bits enter on a write strobe and leave on a system-side read strobe; both strobes are enables on one shared clock. The store holds two frames (512 bits). It tracks how far the read position trails the write position, in whole channels. When that gap leaves a window, it corrects the gap by jumping the read position a full frame, and only at a frame boundary. A frame is either replayed or skipped. The window is asymmetric: a gap under 2 channels grows by 32 channels, and a gap over 60 channels shrinks by 32. This leaves 26 channels (208 bit periods) of wander between the two corrections.

The write side is a valid-only stream. The buffer never applies back-pressure, because slips take the place of stalls. The read side is pulled: every cycle with `rd_ready` high consumes one bit, and that bit is presented with `rd_valid` on the next cycle. A one-cycle slip pulse, a sticky slip flag and a direction flag report each correction; the host clears the two flags with a pulse. A static mode input selects a one-frame store (256 bits) with frame slips disabled. In that mode, bit-level overflow and underflow are handled and flagged.

Top module: `wander_slip_buffer`

## Requirements
- R1: Reset puts the write position at 0 and zero-fills the store. In two-frame mode the read position is 240, so the read trails the write by 34 channels; in one-frame mode it is 128, with 128 bits counted as held. `slip_seen` and `slip_dir` are 0 and `rd_valid` is 0.
- R2: A cycle with `wr_valid` high stores `wr_bit` and advances the write position. A cycle with `rd_ready` high returns one bit on `rd_bit`, with `rd_valid` high, on the following cycle.
- R3: With equal write and read rates in two-frame mode, reads return 272 zero bits followed by the written bits in order. `rd_pos` advances by one per read, modulo 512.
- R4: In two-frame mode, a read at a position whose low 8 bits are all ones is a boundary read. On a boundary read, let gap = (write position before this cycle − (read position + 1)) mod 512. If gap/8 < 2, the next read restarts the frame just read. This is a repeat slip, with `slip_dir` = 1.
- R5: Under the same boundary test, if gap/8 > 60, the next read starts one frame ahead. This is a drop slip, with `slip_dir` = 0.
- R6: No slip occurs when gap/8 is between 2 and 60 inclusive. No two-frame slip happens except on a boundary read, and after a slip `rd_pos` is a frame start (0 or 256).
- R7: Each slip raises `slip_pulse` for exactly one cycle, in the cycle after the triggering strobe. `slip_seen` goes to 1 and `slip_dir` takes the direction. Both hold until a `slip_clr` pulse resets them to 0; a slip in the same cycle as a clear wins.
- R8: With `one_frame` = 1, positions wrap at 256 and no frame slip occurs.
- R9: In one-frame mode, a read while no bits are held returns the previously read bit again. `rd_pos` stays unchanged, and the read flags a slip with `slip_dir` = 1.
- R10: In one-frame mode, a write while 256 bits are held and no read is in the same cycle discards the bit. The write position stays unchanged, and the write flags a slip with `slip_dir` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| one_frame | input | 1 | 1 selects the one-frame store; hold static, change only in reset |
| wr_valid | input | 1 | Line-side bit strobe |
| wr_bit | input | 1 | Line-side data bit |
| rd_ready | input | 1 | System-side read strobe |
| rd_valid | output | 1 | Read data present this cycle |
| rd_bit | output | 1 | Read data bit |
| rd_pos | output | 9 | Current read position (bits 7:0 within frame, bit 8 frame) |
| slip_clr | input | 1 | Host pulse clearing the sticky slip flags |
| slip_pulse | output | 1 | One-cycle slip event |
| slip_dir | output | 1 | Direction of last slip: 1 repeat, 0 drop |
| slip_seen | output | 1 | Sticky slip indication |

## Verification
A wrong gap computation or threshold appears at a single boundary read. The slip either fires when it should not, or fails to fire, and `rd_pos` then differs from the expected frame start on the very next cycle. A read pointer that jumps by the wrong amount, or an off-by-one in the reset offset, corrupts the order of returned bits. That corruption shows within one frame of reads, because the zero-filled region and the pattern region then misalign. In one-frame mode, a bad held-bit count shows up as a missing or misplaced underflow repeat, or as a discarded bit that overwrites unread data, within 256 reads.

// File: rtl/slip_buf_pkg.sv
package slip_buf_pkg;
  typedef enum logic {
    SLIP_DROP   = 1'b0,
    SLIP_REPEAT = 1'b1
  } slip_dir_e;

  typedef struct packed {
    logic      hit;
    slip_dir_e dir;
  } slip_evt_t;
endpackage

// File: rtl/sb_bit_store.sv
module sb_bit_store #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic          rd_valid
);
  logic [DEPTH-1:0] mem;

  // A read and a write to the same address in one cycle return the old bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem      <= '0;
      rd_bit   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_bit;
      rd_valid <= rd_en;
      if (rd_en) rd_bit <= mem[rd_addr];
    end
  end

  a_r2_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/sb_wander_ctl.sv
module sb_wander_ctl
  import slip_buf_pkg::*;
#(
  parameter int CH_BITS      = 8,
  parameter int CH_PER_FRAME = 32,
  parameter int LOW_TH       = 2,
  parameter int HIGH_TH      = 60,
  parameter int RESET_GAP_CH = 34,
  localparam int FRAME_BITS  = CH_BITS * CH_PER_FRAME,
  localparam int DEPTH       = 2 * FRAME_BITS,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          one_frame,
  input  logic          wr_valid,
  input  logic          rd_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] rd_pos,
  output slip_evt_t     evt
);
  localparam int FW  = AW - 1;
  localparam int CSH = $clog2(CH_BITS);
  localparam int CW  = AW - CSH;
  localparam logic [CW-1:0] LOW_C    = CW'(LOW_TH);
  localparam logic [CW-1:0] HIGH_C   = CW'(HIGH_TH);
  localparam logic [AW-1:0] ONE      = AW'(1);
  localparam logic [AW-1:0] RST_RD_N = AW'(DEPTH - RESET_GAP_CH * CH_BITS);
  localparam logic [AW-1:0] RST_RD_S = AW'(FRAME_BITS / 2);
  localparam logic [FW:0]   FILL_RST = (FW+1)'(FRAME_BITS / 2);
  localparam logic [FW:0]   FILL_MAX = (FW+1)'(FRAME_BITS);
  localparam logic [FW:0]   FONE     = (FW+1)'(1);

  logic [AW-1:0] wr_ptr, rd_ptr, rd_inc, rd_prev, gap, rd_nxt, wr_nxt;
  logic [FW:0]   fill, fill_nxt;
  logic [CW-1:0] gap_ch;
  logic          at_last, rep_n, drop_n, under, over, rd_take;

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] p, input logic sf);
    return sf ? {1'b0, p[FW-1:0]} : p;
  endfunction

  always_comb begin
    rd_inc  = fold(rd_ptr + ONE, one_frame);
    rd_prev = fold(rd_ptr - ONE, one_frame);
    at_last = &rd_ptr[FW-1:0];
    gap     = wr_ptr - rd_inc;
    gap_ch  = gap[AW-1:CSH];
    // frame slips: decided only on the read of a frame's last bit
    rep_n   = !one_frame && rd_ready && at_last && (gap_ch < LOW_C);
    drop_n  = !one_frame && rd_ready && at_last && (gap_ch > HIGH_C);
    // bit slips of the one-frame store
    under   = one_frame && rd_ready && (fill == '0);
    over    = one_frame && wr_valid && !rd_ready && (fill == FILL_MAX);
    wr_en   = wr_valid && !over;
    rd_take = rd_ready && !under;
    rd_addr = under ? rd_prev : rd_ptr;
    rd_nxt  = rd_ptr;
    if (rd_take) begin
      // with two frames, one frame back and one frame forward land alike
      rd_nxt = (rep_n || drop_n) ? {~rd_inc[AW-1], rd_inc[AW-2:0]} : rd_inc;
    end
    wr_nxt   = wr_en ? fold(wr_ptr + ONE, one_frame) : wr_ptr;
    fill_nxt = fill;
    if (one_frame) begin
      if (wr_en && !rd_take)      fill_nxt = fill + FONE;
      else if (!wr_en && rd_take) fill_nxt = fill - FONE;
    end
    evt.hit = rep_n || drop_n || under || over;
    evt.dir = (rep_n || under) ? SLIP_REPEAT : SLIP_DROP;
    wr_addr = wr_ptr;
    rd_pos  = rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= one_frame ? RST_RD_S : RST_RD_N;
      fill   <= FILL_RST;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      fill   <= fill_nxt;
    end
  end

  a_r8_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    one_frame |-> fill <= FILL_MAX);
  a_r8_first_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    one_frame |-> !rd_ptr[AW-1] && !wr_ptr[AW-1]);
  a_r10_full_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (one_frame && fill == FILL_MAX && wr_valid && !rd_ready) |=> $stable(wr_ptr));
endmodule

// File: rtl/sb_slip_status.sv
module sb_slip_status
  import slip_buf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slip_evt_t evt,
  input  logic      clr,
  output logic      pulse,
  output logic      seen,
  output slip_dir_e dir
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      seen  <= 1'b0;
      dir   <= SLIP_DROP;
    end else begin
      pulse <= evt.hit;
      if (evt.hit) begin
        seen <= 1'b1;
        dir  <= evt.dir;
      end else if (clr) begin
        seen <= 1'b0;
        dir  <= SLIP_DROP;
      end
    end
  end

  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> seen);
  a_r7_clear_only_by_host: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seen) |-> $past(clr));
  a_r7_single_cycle_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !evt.hit) |=> !pulse);
endmodule

// File: rtl/wander_slip_buffer.sv
module wander_slip_buffer
  import slip_buf_pkg::*;
#(
  parameter int CH_BITS      = 8,
  parameter int CH_PER_FRAME = 32,
  parameter int LOW_TH       = 2,
  parameter int HIGH_TH      = 60,
  parameter int RESET_GAP_CH = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic one_frame,
  input  logic wr_valid,
  input  logic wr_bit,
  input  logic rd_ready,
  output logic rd_valid,
  output logic rd_bit,
  output logic [$clog2(2*CH_BITS*CH_PER_FRAME)-1:0] rd_pos,
  input  logic slip_clr,
  output logic slip_pulse,
  output logic slip_dir,
  output logic slip_seen
);
  localparam int FRAME_BITS = CH_BITS * CH_PER_FRAME;
  localparam int DEPTH      = 2 * FRAME_BITS;
  localparam int AW         = $clog2(DEPTH);
  localparam int FW         = AW - 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  slip_evt_t     evt;
  slip_dir_e     dir_q;

  sb_wander_ctl #(
    .CH_BITS(CH_BITS), .CH_PER_FRAME(CH_PER_FRAME), .LOW_TH(LOW_TH),
    .HIGH_TH(HIGH_TH), .RESET_GAP_CH(RESET_GAP_CH)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .one_frame(one_frame), .wr_valid(wr_valid),
    .rd_ready(rd_ready), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_pos(rd_pos), .evt(evt)
  );

  sb_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .rd_en(rd_ready), .rd_addr(rd_addr), .rd_bit(rd_bit), .rd_valid(rd_valid)
  );

  sb_slip_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(slip_clr),
    .pulse(slip_pulse), .seen(slip_seen), .dir(dir_q)
  );

  assign slip_dir = dir_q;

  // R6: two-frame slips land on a frame start and ride with a read
  a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && !one_frame) |-> rd_valid && rd_pos[FW-1:0] == '0);
  // R9: an underflow read leaves the position where it was
  a_r9_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && one_frame && slip_dir && rd_valid) |-> rd_pos == $past(rd_pos));
endmodule

// File: tb/test_wander_slip_buffer.sv
module test_wander_slip_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic one_frame = 1'b0, wr_valid = 1'b0, wr_bit = 1'b0, rd_ready = 1'b0, slip_clr = 1'b0;
  logic rd_valid, rd_bit, slip_pulse, slip_dir, slip_seen;
  logic [8:0] rd_pos;

  int checks = 0, fails = 0, slip_cnt = 0, s0 = 0;
  bit done = 0;
  logic exp_q[$];

  always #2 clk = ~clk;

  wander_slip_buffer i_wander_slip_buffer (
    .clk(clk), .rst_n(rst_n), .one_frame(one_frame), .wr_valid(wr_valid),
    .wr_bit(wr_bit), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_bit(rd_bit),
    .rd_pos(rd_pos), .slip_clr(slip_clr), .slip_pulse(slip_pulse),
    .slip_dir(slip_dir), .slip_seen(slip_seen)
  );

  function automatic logic pat(input int i);
    return logic'((((i * 5) >> 1) ^ (i >> 3)) & 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every returned bit, counts slip pulses
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3 unexpected read: actual %0b expected none", rd_bit);
        end else begin
          logic e;
          e = exp_q.pop_front();
          if (rd_bit !== e) begin
            fails++;
            $display("FAIL R3 read data: actual %0b expected %0b", rd_bit, e);
          end
        end
      end
      if (slip_pulse) slip_cnt++;
    end
  end

  task automatic step(input logic w, input logic b, input logic r, input logic c = 1'b0);
    wr_valid = w; wr_bit = b; rd_ready = r; slip_clr = c;
    @(posedge clk); #1;
    wr_valid = 0; rd_ready = 0; slip_clr = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic do_reset(input logic sf);
    @(posedge clk); #1;
    rst_n = 0; one_frame = sf; wr_valid = 0; rd_ready = 0; slip_clr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic write_n(input int n);
    for (int k = 0; k < n; k++) step(1'b1, pat(k), 1'b0);
  endtask

  task automatic read_zeros(input int n);
    for (int k = 0; k < n; k++) begin exp_q.push_back(1'b0); step(1'b0, 1'b0, 1'b1); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state, two-frame mode
    do_reset(1'b0);
    chk(rd_pos == 9'd240, "R1 reset rd_pos", rd_pos, 240);
    chk(!slip_seen && !slip_dir, "R1 reset flags", {slip_seen, slip_dir}, 0);
    chk(!rd_valid, "R2 idle rd_valid", rd_valid, 0);

    // R3 matched rates: 272 zeros then the stream in order
    s0 = slip_cnt;
    for (int k = 0; k < 600; k++) begin
      exp_q.push_back(k < 272 ? 1'b0 : pat(k - 272));
      step(1'b1, pat(k), 1'b1);
    end
    settle();
    chk(slip_cnt == s0, "R6 no slip at matched rate", slip_cnt - s0, 0);
    chk(rd_pos == 9'd328, "R3 read position", rd_pos, 328);

    // R4 repeat slip: reads only, gap reaches 0 at the 511 boundary
    do_reset(1'b0);
    read_zeros(272);
    chk(slip_pulse == 1'b1, "R7 pulse with boundary read", slip_pulse, 1);
    chk(slip_dir == 1'b1, "R4 repeat direction", slip_dir, 1);
    chk(slip_seen == 1'b1, "R7 sticky set", slip_seen, 1);
    chk(rd_pos == 9'd256, "R4 frame restarted", rd_pos, 256);
    step(1'b0, 1'b0, 1'b0);
    chk(slip_pulse == 1'b0, "R7 pulse one cycle", slip_pulse, 0);
    chk(slip_seen == 1'b1, "R7 sticky holds", slip_seen, 1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(!slip_seen && !slip_dir, "R7 host clear", {slip_seen, slip_dir}, 0);

    // R6 low edge: gap of exactly 2 channels, no slip
    do_reset(1'b0);
    write_n(16);
    s0 = slip_cnt;
    read_zeros(272);
    settle();
    chk(slip_cnt == s0, "R6 gap 2 channels no slip", slip_cnt - s0, 0);
    chk(rd_pos == 9'd0, "R6 no jump at low edge", rd_pos, 0);
    for (int k = 0; k < 16; k++) begin exp_q.push_back(pat(k)); step(1'b0, 1'b0, 1'b1); end

    // R4 gap of 1 channel slips
    do_reset(1'b0);
    write_n(15);
    read_zeros(272);
    chk(slip_pulse == 1'b1 && slip_dir == 1'b1, "R4 gap 1 channel repeats", {slip_pulse, slip_dir}, 3);

    // R5 drop slip: gap 61 channels at the 255 boundary
    do_reset(1'b0);
    write_n(232);
    read_zeros(16);
    chk(slip_pulse == 1'b1, "R5 drop pulse", slip_pulse, 1);
    chk(slip_dir == 1'b0, "R5 drop direction", slip_dir, 0);
    chk(rd_pos == 9'd0, "R5 frame skipped", rd_pos, 0);
    for (int k = 0; k < 232; k++) begin exp_q.push_back(pat(k)); step(1'b0, 1'b0, 1'b1); end
    chk(rd_pos == 9'd232, "R5 read continues", rd_pos, 232);

    // R6 high edge: gap of exactly 60 channels, no slip
    do_reset(1'b0);
    write_n(231);
    s0 = slip_cnt;
    read_zeros(16);
    settle();
    chk(slip_cnt == s0, "R6 gap 60 channels no slip", slip_cnt - s0, 0);
    chk(rd_pos == 9'd256, "R6 no jump at high edge", rd_pos, 256);

    // R8/R9 one-frame mode and underflow
    do_reset(1'b1);
    chk(rd_pos == 9'd128, "R1 one-frame reset rd_pos", rd_pos, 128);
    s0 = slip_cnt;
    read_zeros(128);
    settle();
    chk(slip_cnt == s0, "R8 no frame slip", slip_cnt - s0, 0);
    chk(rd_pos == 9'd0, "R8 wrap at 256", rd_pos, 0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    exp_q.push_back(1'b0); step(1'b0, 1'b0, 1'b1);
    exp_q.push_back(1'b1); step(1'b0, 1'b0, 1'b1);
    exp_q.push_back(1'b1); step(1'b0, 1'b0, 1'b1);
    chk(slip_pulse == 1'b1 && slip_dir == 1'b1, "R9 underflow flagged", {slip_pulse, slip_dir}, 3);
    chk(rd_pos == 9'd2, "R9 position held", rd_pos, 2);

    // R10 one-frame overflow discards the bit
    do_reset(1'b1);
    write_n(128);
    step(1'b1, 1'b1, 1'b0);
    chk(slip_pulse == 1'b1 && slip_dir == 1'b0, "R10 overflow flagged", {slip_pulse, slip_dir}, 2);
    read_zeros(128);
    for (int k = 0; k < 128; k++) begin exp_q.push_back(pat(k)); step(1'b0, 1'b0, 1'b1); end
    exp_q.push_back(pat(127)); step(1'b0, 1'b0, 1'b1);
    chk(slip_dir == 1'b1, "R9 repeat after drain", slip_dir, 1);

    settle();
    chk(exp_q.size() == 0, "R2 every read returned", exp_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule